// File: doc/BRIEF.md
# Programmable Vectored Interrupt Controller

This block merges eight interrupt request lines into one interrupt line to the processor. When the processor acknowledges, the block hands back an 8-bit vector. Software talks to it through a register port with two addresses and an 8-bit data bus. Address 0 is the command port and address 1 is the data port.

Before normal operation, software writes a short configuration sequence. The first word goes to the command port with bit 4 set. That word chooses edge or level triggering, single or chained operation, and whether a fourth word will follow. The following data-port writes then supply:
- the vector base,
- the chaining word, when chained,
- the optional fourth word, which holds the automatic end-of-interrupt and master/slave role bits.

Once the sequence is done, data-port writes load the mask and data-port reads return it. A command write of 0x20 retires the most urgent interrupt in service. Priority is fixed, with input 0 the most urgent. A higher-priority request may nest over one already in service.

The sequencer passes through these states:
- `ST_UNINIT` is the state after reset.
- `ST_WORD2` waits for the base. Every first word leads here, from any state.
- `ST_WORD3` is entered from `ST_WORD2` when chained.
- `ST_WORD4` is entered from `ST_WORD2` or `ST_WORD3` when the first word asked for it.
- `ST_RUN` is the normal operating state. It is reached after the last required word.

Top module: `vic_top`

## Requirements
- R1: After reset, `int_out` is low, a data-port read returns 0xFF, and `vector` and `vec_drive` are 0.
- R2: A command write with bit 4 set begins configuration. The next data write sets the vector base. A third word is taken only when bit 1 of the first word is clear. A fourth word is taken only when bit 0 of the first word is set. After that, data writes load the mask and data reads return it.
- R3: A first word clears the mask (reads 0x00) and the in-service set. It also discards latched requests and restarts the sequence at the base word.
- R4: `int_out` can be high only in the run state. It rises one clock edge after a request appears on an input whose mask bit is 0. A mask bit of 1 blocks its input.
- R5: Input 0 has the highest priority. When several requests are pending, the vector is base plus the lowest requesting index.
- R6: On the clock edge that samples `ack` with `int_out` high, the winning request moves into the in-service set. From the next cycle `vector` holds base plus index.
- R7: A request of lower or equal priority than the most urgent in-service bit does not raise `int_out`. A higher one does.
- R8: A command write with bits 5:3 = 100 clears the most urgent in-service bit. Held-off requests become eligible on the same edge.
- R9: When bit 1 of the fourth word is set, an acknowledged request never enters the in-service set.
- R10: Bit 3 of the first word selects level mode. In level mode a request is withdrawn one edge after its input falls. In edge mode a rising edge stays latched until acknowledged.
- R11: `vec_drive` is low after an acknowledge only when the controller is a master and the winner has a slave. Master means bit 2 of the fourth word is set, or no fourth word was written. The winner has a slave when its bit is set in the third word. In single mode `vec_drive` is always high.
- R12: An acknowledge while `int_out` is low returns base plus 7 and leaves the in-service set unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 1 | 0 = command port, 1 = data port |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (mask on the data port, 0 otherwise) |
| irq_in | input | 8 | Interrupt request lines |
| int_out | output | 1 | Interrupt to processor |
| ack | input | 1 | Acknowledge pulse |
| vector | output | 8 | Vector captured on acknowledge |
| vec_drive | output | 1 | This controller supplies the vector |

## Verification
The results fall due at three different times:
- Register writes and input changes become visible at `int_out` one clock edge later, so the bench drives on the falling edge and samples on the following falling edge.
- `vector` and `vec_drive` are registered on the edge that samples `ack`, and are checked half a cycle after that edge.
- Mask reads are combinational and are sampled while the read strobe is held.

The level-mode re-request after an automatic end of interrupt is checked twice. It must be low right after the acknowledge and high exactly one cycle later.

// File: rtl/vic_pkg.sv
package vic_pkg;
    typedef enum logic [2:0] {
        ST_UNINIT,
        ST_WORD2,
        ST_WORD3,
        ST_WORD4,
        ST_RUN
    } vic_state_e;
endpackage

// File: rtl/vic_seq.sv
module vic_seq
    import vic_pkg::*;
#(
    parameter int DW = 8,
    parameter int N  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          dat_wr,
    input  logic [DW-1:0] wdata,
    output logic          run,
    output logic          level_mode,
    output logic          single_mode,
    output logic          auto_eoi,
    output logic          master_role,
    output logic [DW-1:0] base,
    output logic [N-1:0]  cas_cfg
);
    vic_state_e state, state_nx;
    logic       need_w4;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_UNINIT;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (start) begin
            state_nx = ST_WORD2;
        end else if (dat_wr) begin
            unique case (state)
                ST_UNINIT: state_nx = ST_UNINIT;
                ST_WORD2:  state_nx = !single_mode ? ST_WORD3 :
                                      (need_w4 ? ST_WORD4 : ST_RUN);
                ST_WORD3:  state_nx = need_w4 ? ST_WORD4 : ST_RUN;
                ST_WORD4:  state_nx = ST_RUN;
                ST_RUN:    state_nx = ST_RUN;
                default:   state_nx = ST_UNINIT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_mode  <= 1'b0;
            single_mode <= 1'b1;
            need_w4     <= 1'b0;
            auto_eoi    <= 1'b0;
            master_role <= 1'b1;
            base        <= '0;
            cas_cfg     <= '0;
        end else if (start) begin
            level_mode  <= wdata[3];
            single_mode <= wdata[1];
            need_w4     <= wdata[0];
            auto_eoi    <= 1'b0;
            master_role <= 1'b1;
            cas_cfg     <= '0;
        end else if (dat_wr) begin
            unique case (state)
                ST_WORD2: base    <= wdata;
                ST_WORD3: cas_cfg <= wdata[N-1:0];
                ST_WORD4: begin
                    auto_eoi    <= wdata[1];
                    master_role <= wdata[2];
                end
                default: ;
            endcase
        end
    end

    assign run = (state == ST_RUN);
endmodule

// File: rtl/vic_req.sv
module vic_req #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         level_mode,
    input  logic [N-1:0] irq_in,
    input  logic [N-1:0] take,
    output logic [N-1:0] irr
);
    logic [N-1:0] prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev <= '0;
            irr  <= '0;
        end else begin
            prev <= irq_in;
            if (clear)           irr <= '0;
            else if (level_mode) irr <= irq_in & ~take;
            else                 irr <= (irr | (irq_in & ~prev)) & ~take;
        end
    end
endmodule

// File: rtl/vic_pick.sv
module vic_pick #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req,
    input  logic [N-1:0]  isr,
    output logic          found,
    output logic [IW-1:0] win,
    output logic          isr_found,
    output logic [IW-1:0] isr_low,
    output logic          grant
);
    always_comb begin
        found     = 1'b0;
        win       = '0;
        isr_found = 1'b0;
        isr_low   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                win   = IW'(i);
            end
            if (isr[i]) begin
                isr_found = 1'b1;
                isr_low   = IW'(i);
            end
        end
        grant = found && (!isr_found || (isr_low > win));
    end
endmodule

// File: rtl/vic_top.sv
module vic_top #(
    parameter int N  = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          addr,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic [N-1:0]  irq_in,
    output logic          int_out,
    input  logic          ack,
    output logic [DW-1:0] vector,
    output logic          vec_drive
);
    localparam int IW = $clog2(N);

    logic          run, level_mode, single_mode, auto_eoi, master_role;
    logic [DW-1:0] base;
    logic [N-1:0]  cas_cfg, irr, mask, isr, take, isr_nx;
    logic          found, isr_found, grant;
    logic [IW-1:0] win, isr_low;

    wire cmd_wr = wr_en && !addr;
    wire dat_wr = wr_en && addr;
    wire start  = cmd_wr && wdata[4];
    wire eoi    = cmd_wr && run && (wdata[5:3] == 3'b100);
    wire taken  = ack && run && grant;

    vic_seq #(.DW(DW), .N(N)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .dat_wr(dat_wr),
        .wdata(wdata), .run(run), .level_mode(level_mode),
        .single_mode(single_mode), .auto_eoi(auto_eoi),
        .master_role(master_role), .base(base), .cas_cfg(cas_cfg)
    );

    vic_req #(.N(N)) u_req (
        .clk(clk), .rst_n(rst_n), .clear(start), .level_mode(level_mode),
        .irq_in(irq_in), .take(take), .irr(irr)
    );

    vic_pick #(.N(N), .IW(IW)) u_pick (
        .req(irr & ~mask), .isr(isr), .found(found), .win(win),
        .isr_found(isr_found), .isr_low(isr_low), .grant(grant)
    );

    always_comb begin
        take = '0;
        if (taken) take[win] = 1'b1;
        isr_nx = isr;
        if (eoi && isr_found) isr_nx[isr_low] = 1'b0;
        if (taken && !auto_eoi) isr_nx = isr_nx | take;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask      <= '1;
            isr       <= '0;
            vector    <= '0;
            vec_drive <= 1'b0;
        end else begin
            if (start)              mask <= '0;
            else if (dat_wr && run) mask <= wdata[N-1:0];
            isr <= start ? '0 : isr_nx;
            if (ack && run) begin
                if (grant) begin
                    vector    <= base + DW'(win);
                    vec_drive <= single_mode || !master_role || !cas_cfg[win];
                end else begin
                    vector    <= base + DW'(N - 1);
                    vec_drive <= 1'b1;
                end
            end
        end
    end

    assign int_out = run && grant;
    assign rdata   = (rd_en && addr) ? DW'(mask) : '0;
endmodule

// File: rtl/vic_checks.sv
module vic_checks #(
    parameter int N  = 8,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          run,
    input logic          int_out,
    input logic          ack,
    input logic          wr_en,
    input logic          addr,
    input logic [DW-1:0] wdata,
    input logic [N-1:0]  isr,
    input logic [N-1:0]  mask,
    input logic [N-1:0]  irr,
    input logic          auto_eoi
);
    a_r4_quiet_until_run: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !int_out);

    a_r4_int_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> |(irr & ~mask));

    a_r6_ack_enters_service: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && int_out && !wr_en && !auto_eoi) |=>
            ($countones(isr) == $countones($past(isr)) + 1));

    a_r9_auto_eoi_no_service: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && int_out && !wr_en && auto_eoi) |=> $stable(isr));

    a_r8_eoi_drops_one: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr && run && wdata[5:3] == 3'b100 && (|isr) && !ack) |=>
            ($countones(isr) + 1 == $countones($past(isr))));

    a_r3_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr && wdata[4]) |=> (isr == '0 && mask == '0));

    a_r12_spurious_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !int_out && !wr_en) |=> $stable(isr));
endmodule

bind vic_top vic_checks #(.N(N), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(run), .int_out(int_out), .ack(ack),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .isr(isr), .mask(mask),
    .irr(irr), .auto_eoi(auto_eoi)
);

// File: tb/vic_top_test.sv
module vic_top_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr = 1'b0, wr_en = 1'b0, rd_en = 1'b0, ack = 1'b0;
    logic [7:0] wdata = '0, irq = '0;
    logic [7:0] rdata, vector;
    logic       int_out, vec_drive;
    int         n_chk = 0, n_bad = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    vic_top uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .irq_in(irq), .int_out(int_out),
        .ack(ack), .vector(vector), .vec_drive(vec_drive)
    );

    // {op, addr, data, expect}; op 0 write, 1 read mask, 2 set irq + check int, 3 ack + check vector
    localparam logic [18:0] TBL [15] = '{
        {2'd0, 1'b0, 8'h11, 8'h00},
        {2'd0, 1'b1, 8'h40, 8'h00},
        {2'd0, 1'b1, 8'h04, 8'h00},
        {2'd0, 1'b1, 8'h05, 8'h00},
        {2'd1, 1'b1, 8'h00, 8'h00},
        {2'd0, 1'b1, 8'hF0, 8'h00},
        {2'd1, 1'b1, 8'h00, 8'hF0},
        {2'd2, 1'b0, 8'h08, 8'h01},
        {2'd3, 1'b0, 8'h00, 8'h43},
        {2'd2, 1'b0, 8'h08, 8'h00},
        {2'd2, 1'b0, 8'h0A, 8'h01},
        {2'd3, 1'b0, 8'h00, 8'h41},
        {2'd0, 1'b0, 8'h20, 8'h00},
        {2'd0, 1'b0, 8'h20, 8'h00},
        {2'd2, 1'b0, 8'h0A, 8'h00}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd_mask(input string req, input logic [7:0] exp);
        @(negedge clk); addr = 1'b1; rd_en = 1'b1;
        #1 chk(req, rdata, exp);
        rd_en = 1'b0;
    endtask

    task automatic set_irq(input logic [7:0] v);
        @(negedge clk); irq = v;
        @(negedge clk);
    endtask

    task automatic do_ack;
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
    endtask

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        @(negedge clk);
        chk("R1 int", {7'd0, int_out}, 8'h00);
        chk("R1 vector", vector, 8'h00);
        chk("R1 drive", {7'd0, vec_drive}, 8'h00);
        rd_mask("R1 mask", 8'hFF);

        // Table: chained master, edge, base 0x40 (R2 R4 R5 R6 R7 R8)
        for (int i = 0; i < 15; i++) begin
            unique case (TBL[i][18:17])
                2'd0: wr(TBL[i][16], TBL[i][15:8]);
                2'd1: rd_mask("R2 mask readback", TBL[i][7:0]);
                2'd2: begin
                    set_irq(TBL[i][15:8]);
                    chk("R4/R7 int", {7'd0, int_out}, TBL[i][7:0]);
                end
                default: begin
                    do_ack();
                    chk("R6 vector", vector, TBL[i][7:0]);
                end
            endcase
        end

        // R12 spurious acknowledge
        do_ack();
        chk("R12 vector", vector, 8'h47);
        chk("R12 int", {7'd0, int_out}, 8'h00);

        // R11 cascade decode on master
        set_irq(8'h00);
        set_irq(8'h04);
        chk("R11 int", {7'd0, int_out}, 8'h01);
        do_ack();
        chk("R11 vector", vector, 8'h42);
        chk("R11 slave input drive", {7'd0, vec_drive}, 8'h00);
        wr(1'b0, 8'h20);
        set_irq(8'h00);
        set_irq(8'h01);
        do_ack();
        chk("R11 vector own", vector, 8'h40);
        chk("R11 own input drive", {7'd0, vec_drive}, 8'h01);

        // R3 re-initialise while bit 0 in service; single, no fourth word
        set_irq(8'h00);
        wr(1'b0, 8'h12);
        rd_mask("R3 mask cleared", 8'h00);
        wr(1'b1, 8'h20);
        wr(1'b1, 8'hAA);
        rd_mask("R2 no third/fourth word", 8'hAA);
        wr(1'b1, 8'h00);
        set_irq(8'h02);
        chk("R3 service cleared", {7'd0, int_out}, 8'h01);
        do_ack();
        chk("R2 new base", vector, 8'h21);
        set_irq(8'h06);
        chk("R7 lower blocked", {7'd0, int_out}, 8'h00);
        set_irq(8'h00);
        chk("R10 edge latched blocked", {7'd0, int_out}, 8'h00);
        wr(1'b0, 8'h20);
        chk("R8 eoi releases", {7'd0, int_out}, 8'h01);
        do_ack();
        chk("R10 edge latched vector", vector, 8'h22);
        wr(1'b0, 8'h20);

        // Level, single, automatic EOI, base 0x80 (R9 R10 R5)
        wr(1'b0, 8'h1B);
        wr(1'b1, 8'h80);
        wr(1'b1, 8'h03);
        wr(1'b1, 8'h00);
        rd_mask("R2 mask after fourth word", 8'h00);
        set_irq(8'h20);
        chk("R4 level int", {7'd0, int_out}, 8'h01);
        do_ack();
        chk("R9 vector", vector, 8'h85);
        chk("R11 single drive", {7'd0, vec_drive}, 8'h01);
        chk("R9 int after ack", {7'd0, int_out}, 8'h00);
        @(negedge clk);
        chk("R9 no service hold", {7'd0, int_out}, 8'h01);
        set_irq(8'h00);
        chk("R10 level withdrawn", {7'd0, int_out}, 8'h00);
        set_irq(8'h60);
        do_ack();
        chk("R5 priority", vector, 8'h85);
        wr(1'b1, 8'hFF);
        chk("R4 masked", {7'd0, int_out}, 8'h00);

        done = 1'b1;
        finish_run();
    end
endmodule